// File: doc/BRIEF.md
# Serial Strobe-Framed Command Decoder

This block receives bytes from a host over three wires: a strobe that marks a transfer frame, a shift clock, and a data line. All three are brought into the system clock domain. Bits are shifted in MSB first on rising shift-clock edges, but only while the strobe is low. The first byte of each frame is a command. Every later byte in the same frame is display data and leaves the block with a one-cycle valid pulse and the RAM group address it belongs to.

The top two bits of a command select one of four classes. The classes set the display mode, the data-transfer settings, the status flags, or the group address. The address steps forward after each data byte and wraps at the last address of the current duty. When the strobe rises, the block can copy the display-on request to its output, reset the address, and start an output latch. During a latch the busy output is held low for a fixed number of cycles. If a strobe edge arrives while busy is low, the block restarts the link and switches the display off.

Top module: `strobe_cmd_decoder`

## Requirements
- R1: A data bit is taken on each rising shift-clock edge while the strobe is low, MSB first. Shift-clock edges while the strobe is high have no effect.
- R2: The first complete byte after the strobe falls is decoded as a command. Each later byte in the same frame appears on `data_o` with a one-cycle `data_valid_o` and the group address it was written to on `data_addr_o`.
- R3: Command class 00 (bits 7:6) sets the following fields:
  - `frame_div_o` from bits 3:2.
  - The mode from bits 1:0. Codes 00 and 01 give `duty_o`=0 (1/2) with `bias_third_o`=0. Code 10 gives `duty_o`=1 (1/3) with `bias_third_o`=1. Code 11 gives `duty_o`=2 (1/4) with `bias_third_o`=1.
- R4: Command class 01 sets the following fields:
  - Bit 3 to `latch_md_o`.
  - Bit 2 to `addr_hold_o` (0 = auto-increment).
  - Bits 1:0 to `wr_mode_o`. The prohibited codes 10 and 11 are recorded but still handled as writes: data bytes keep producing valid pulses.
- R5: Command class 10 sets the following fields:
  - Bits 5:4 to `test_ms_o`.
  - Bit 3 to `int_bias_o`.
  - Bit 2 to `addr_rst_o`.
  - Bit 1 to `latch_flag_o`.
  - Bit 0 to a display-on request. The request reaches `disp_on_o` only at the next rising strobe edge.
- R6: Command class 11 loads `grp_addr_o` from bits 4:0.
- R7: With auto-increment, the address advances after each data byte. It returns to 0 after the last address, which is 14, 19 or 29 for the 1/2, 1/3 and 1/4 duty. With address hold, the address stays where it is.
- R8: On a rising strobe, the address goes to 0 if the address-reset flag is set and the frame carried at least one data byte. A frame with no data leaves the address unchanged.
- R9: A rising strobe while busy is high starts a latch in either of these cases:
  - The latch flag is set.
  - Latch mode is set and the frame carried data.
  A latch gives a one-cycle `latch_o` and holds `busy_o` low for `LATCH_CYCLES` cycles.
- R10: A strobe edge of either polarity while busy is low ends the busy-low state at once, clears `disp_on_o` and the pending request, and restarts the link. A falling edge also opens a new frame.
- R11: After reset, all configuration outputs are 0 and `busy_o` stays low until the first strobe edge, after which it is high.
- R12: A partial byte is discarded when the strobe rises before eight bits have arrived. The next frame starts its byte count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| stb_i | input | 1 | Frame strobe, active low |
| sck_i | input | 1 | Shift clock |
| sdi_i | input | 1 | Serial data |
| busy_o | output | 1 | High when ready, low during a latch and after reset |
| latch_o | output | 1 | One-cycle latch request |
| data_o | output | 8 | Received display byte |
| data_valid_o | output | 1 | Display byte valid |
| data_addr_o | output | 5 | Group address of the byte |
| grp_addr_o | output | 5 | Current group address |
| frame_div_o | output | 2 | Frame divider select |
| duty_o | output | 2 | 0: 1/2, 1: 1/3, 2: 1/4 duty |
| bias_third_o | output | 1 | 1/3 bias selected |
| latch_md_o | output | 1 | Latch after data input |
| addr_hold_o | output | 1 | Address hold, auto-increment off |
| wr_mode_o | output | 2 | Recorded write-mode code |
| test_ms_o | output | 2 | Test / master-slave field |
| int_bias_o | output | 1 | Internal drive voltage selected |
| addr_rst_o | output | 1 | Address reset flag |
| latch_flag_o | output | 1 | Latch on every rising strobe |
| disp_on_o | output | 1 | Applied display-on state |

## Verification
The bench checks the address wrap at 19 under 1/3 duty; a design with a fixed or off-by-one limit would give address 20 or skip address 19. It aborts a latch with a falling strobe and then decodes a command in that same frame; a design that ignored the abort, or that dropped the frame the abort opened, would leave the display on or lose the address. It also checks the following corner cases:
- Shift-clock pulses while the strobe is high, and a three-bit partial frame. A design that let either leak in would misalign the next command.
- Frames that carry no data. A design that did not track data within a frame would reset the address or latch wrongly.

// File: rtl/strobe_cmd_decoder.sv
module strobe_cmd_decoder #(
  parameter int LATCH_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb_i,
  input  logic       sck_i,
  input  logic       sdi_i,
  output logic       busy_o,
  output logic       latch_o,
  output logic [7:0] data_o,
  output logic       data_valid_o,
  output logic [4:0] data_addr_o,
  output logic [4:0] grp_addr_o,
  output logic [1:0] frame_div_o,
  output logic [1:0] duty_o,
  output logic       bias_third_o,
  output logic       latch_md_o,
  output logic       addr_hold_o,
  output logic [1:0] wr_mode_o,
  output logic [1:0] test_ms_o,
  output logic       int_bias_o,
  output logic       addr_rst_o,
  output logic       latch_flag_o,
  output logic       disp_on_o
);

  localparam int CNT_W = $clog2(LATCH_CYCLES + 1);

  logic [2:0]       stb_sr, sck_sr;
  logic [1:0]       sdi_sr;
  logic [CNT_W-1:0] lcnt;
  logic [2:0]       bitcnt;
  logic [6:0]       shreg;
  logic             awake, first, got_data, disp_pend;
  logic [1:0]       mode_code;
  logic [4:0]       last_addr;

  wire stb_q     = stb_sr[1];
  wire stb_rise  = ~stb_sr[2] & stb_sr[1];
  wire stb_fall  = stb_sr[2] & ~stb_sr[1];
  wire stb_edge  = stb_rise | stb_fall;
  wire sck_rise  = ~sck_sr[2] & sck_sr[1];
  wire [7:0] rx_byte = {shreg, sdi_sr[1]};

  assign busy_o       = awake && (lcnt == '0);
  assign duty_o       = mode_code[1] ? {mode_code[0], ~mode_code[0]} : 2'd0;
  assign bias_third_o = mode_code[1];
  assign last_addr    = (duty_o == 2'd0) ? 5'd14 : (duty_o == 2'd1) ? 5'd19 : 5'd29;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_sr       <= 3'b111;
      sck_sr       <= '0;
      sdi_sr       <= '0;
      lcnt         <= '0;
      bitcnt       <= '0;
      shreg        <= '0;
      awake        <= 1'b0;
      first        <= 1'b0;
      got_data     <= 1'b0;
      disp_pend    <= 1'b0;
      mode_code    <= '0;
      latch_o      <= 1'b0;
      data_o       <= '0;
      data_valid_o <= 1'b0;
      data_addr_o  <= '0;
      grp_addr_o   <= '0;
      frame_div_o  <= '0;
      latch_md_o   <= 1'b0;
      addr_hold_o  <= 1'b0;
      wr_mode_o    <= '0;
      test_ms_o    <= '0;
      int_bias_o   <= 1'b0;
      addr_rst_o   <= 1'b0;
      latch_flag_o <= 1'b0;
      disp_on_o    <= 1'b0;
    end else begin
      stb_sr       <= {stb_sr[1:0], stb_i};
      sck_sr       <= {sck_sr[1:0], sck_i};
      sdi_sr       <= {sdi_sr[0], sdi_i};
      data_valid_o <= 1'b0;
      latch_o      <= 1'b0;
      if (lcnt != '0) lcnt <= lcnt - 1'b1;

      if (stb_edge && !busy_o) begin
        awake     <= 1'b1;
        lcnt      <= '0;
        disp_on_o <= 1'b0;
        disp_pend <= 1'b0;
        bitcnt    <= '0;
        first     <= stb_fall;
        got_data  <= 1'b0;
      end else if (stb_fall) begin
        bitcnt   <= '0;
        first    <= 1'b1;
        got_data <= 1'b0;
      end else if (stb_rise) begin
        bitcnt    <= '0;
        first     <= 1'b0;
        disp_on_o <= disp_pend;
        if (addr_rst_o && got_data) grp_addr_o <= '0;
        if (latch_flag_o || (latch_md_o && got_data)) begin
          latch_o <= 1'b1;
          lcnt    <= CNT_W'(LATCH_CYCLES);
        end
      end else if (sck_rise && !stb_q) begin
        shreg  <= rx_byte[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          if (first) begin
            first <= 1'b0;
            unique case (rx_byte[7:6])
              2'b00: begin
                frame_div_o <= rx_byte[3:2];
                mode_code   <= rx_byte[1:0];
              end
              2'b01: begin
                latch_md_o  <= rx_byte[3];
                addr_hold_o <= rx_byte[2];
                wr_mode_o   <= rx_byte[1:0];
              end
              2'b10: begin
                test_ms_o    <= rx_byte[5:4];
                int_bias_o   <= rx_byte[3];
                addr_rst_o   <= rx_byte[2];
                latch_flag_o <= rx_byte[1];
                disp_pend    <= rx_byte[0];
              end
              default: grp_addr_o <= rx_byte[4:0];
            endcase
          end else begin
            data_valid_o <= 1'b1;
            data_o       <= rx_byte;
            data_addr_o  <= grp_addr_o;
            got_data     <= 1'b1;
            if (!addr_hold_o)
              grp_addr_o <= (grp_addr_o >= last_addr) ? 5'd0 : grp_addr_o + 5'd1;
          end
        end
      end
    end
  end

  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |-> !stb_sr[2]); // R2
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_edge && !busy_o) |=> (busy_o && !disp_on_o)); // R10
  AST_LATCH_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |=> !busy_o); // R9
  AST_DISP_ON_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_on_o) |-> $past(stb_rise)); // R5
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid_o && !addr_hold_o && data_addr_o == last_addr) |-> grp_addr_o == 5'd0); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid_o && addr_hold_o) |-> grp_addr_o == data_addr_o); // R7

endmodule

// File: tb/tb_strobe_cmd_decoder.sv
module tb_strobe_cmd_decoder;
  logic clk = 0, rst_n = 0, stb = 1, sck = 0, sdi = 0;
  logic busy, latch, dv, bias3, lmd, hold, ibias, arst, lflag, don;
  logic [7:0] dat;
  logic [4:0] daddr, gaddr;
  logic [1:0] fdiv, duty, wrm, tms;
  int tests = 0, fails = 0;
  int vcount = 0, lcount = 0;
  logic [7:0] vdat [0:63];
  logic [4:0] vadr [0:63];

  always #5 clk = ~clk;

  strobe_cmd_decoder #(.LATCH_CYCLES(64)) dut (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .sck_i(sck), .sdi_i(sdi),
    .busy_o(busy), .latch_o(latch), .data_o(dat), .data_valid_o(dv),
    .data_addr_o(daddr), .grp_addr_o(gaddr), .frame_div_o(fdiv), .duty_o(duty),
    .bias_third_o(bias3), .latch_md_o(lmd), .addr_hold_o(hold), .wr_mode_o(wrm),
    .test_ms_o(tms), .int_bias_o(ibias), .addr_rst_o(arst), .latch_flag_o(lflag),
    .disp_on_o(don));

  always @(negedge clk) begin
    if (dv && vcount < 64) begin
      vdat[vcount] = dat;
      vadr[vcount] = daddr;
      vcount++;
    end
    if (latch) lcount++;
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      wclk(3);
      sck = 1;
      wclk(4);
      sck = 0;
      wclk(3);
    end
  endtask

  task automatic fall();
    stb = 0;
    wclk(8);
  endtask

  task automatic rise();
    stb = 1;
    wclk(10);
  endtask

  task automatic cmd(logic [7:0] c);
    fall();
    send_byte(c);
    rise();
  endtask

  task automatic t_reset();
    check("R11 busy after reset", busy, 0);
    check("R11 addr after reset", gaddr, 0);
    check("R11 duty after reset", duty, 0);
    check("R11 disp after reset", don, 0);
    fall();
    check("R11 busy after first edge", busy, 1);
    rise();
  endtask

  task automatic t_mode();
    cmd(8'h0E);
    check("R3 frame div", fdiv, 3);
    check("R3 duty 1/3", duty, 1);
    check("R3 bias 1/3", bias3, 1);
    cmd(8'h07);
    check("R3 frame div 01", fdiv, 1);
    check("R3 duty 1/4", duty, 2);
    cmd(8'h01);
    check("R3 mode 01 duty", duty, 0);
    check("R3 mode 01 bias", bias3, 0);
  endtask

  task automatic t_data_set();
    int v0;
    cmd(8'h4E);
    check("R4 latch md", lmd, 1);
    check("R4 hold", hold, 1);
    check("R4 wr mode", wrm, 2);
    v0 = vcount;
    fall();
    send_byte(8'h43);
    send_byte(8'h11);
    send_byte(8'h22);
    rise();
    check("R4 wr mode 11 recorded", wrm, 3);
    check("R4 prohibited mode still writes", vcount - v0, 2);
    check("R4 hold cleared", hold, 0);
    cmd(8'h40);
  endtask

  task automatic t_status();
    cmd(8'hB5);
    check("R5 test field", tms, 3);
    check("R5 int bias", ibias, 0);
    check("R5 addr rst", arst, 1);
    check("R5 latch flag", lflag, 0);
    fall();
    send_byte(8'h9A);
    wclk(8);
    check("R5 disp waits for rise", don, 1);
    check("R5 int bias set", ibias, 1);
    rise();
    check("R5 disp off applied at rise", don, 0);
    fall();
    send_byte(8'h81);
    wclk(8);
    check("R5 disp not yet on", don, 0);
    rise();
    check("R5 disp on at rise", don, 1);
    cmd(8'h80);
    check("R5 disp off again", don, 0);
  endtask

  task automatic t_addr_inc();
    int v0;
    cmd(8'h02);
    v0 = vcount;
    fall();
    send_byte(8'hD2);
    send_byte(8'hA5);
    send_byte(8'h3C);
    send_byte(8'h81);
    rise();
    check("R6 addr cmd then data addr", vadr[v0], 18);
    check("R1 MSB first value", vdat[v0], 8'hA5);
    check("R2 second data byte", vdat[v0+1], 8'h3C);
    check("R7 last addr 1/3", vadr[v0+1], 19);
    check("R7 wrap to 0", vadr[v0+2], 0);
    check("R7 addr after wrap", gaddr, 1);
    cmd(8'h44);
    v0 = vcount;
    fall();
    send_byte(8'hC3);
    send_byte(8'h01);
    send_byte(8'h02);
    rise();
    check("R7 hold first", vadr[v0], 3);
    check("R7 hold second", vadr[v0+1], 3);
    cmd(8'h40);
    cmd(8'h01);
  endtask

  task automatic t_ignore();
    int v0;
    v0 = vcount;
    for (int i = 0; i < 5; i++) begin
      sdi = i[0];
      wclk(3); sck = 1; wclk(4); sck = 0; wclk(3);
    end
    cmd(8'hC5);
    check("R1 high-strobe clocks ignored", gaddr, 5);
    check("R1 no data from ignored clocks", vcount - v0, 0);
  endtask

  task automatic t_partial();
    int v0;
    v0 = vcount;
    fall();
    for (int i = 0; i < 3; i++) begin
      sdi = 1;
      wclk(3); sck = 1; wclk(4); sck = 0; wclk(3);
    end
    rise();
    check("R12 partial no effect on addr", gaddr, 5);
    check("R12 partial no effect on mode", duty, 0);
    cmd(8'hC7);
    check("R12 next frame aligned", gaddr, 7);
    check("R12 no data pulse", vcount - v0, 0);
  endtask

  task automatic t_addr_rst();
    cmd(8'h84);
    cmd(8'hC6);
    check("R8 no reset without data", gaddr, 6);
    fall();
    send_byte(8'hC4);
    send_byte(8'h55);
    wclk(4);
    check("R8 incremented before rise", gaddr, 5);
    rise();
    check("R8 reset at rise after data", gaddr, 0);
    cmd(8'h80);
  endtask

  task automatic t_latch();
    int l0;
    l0 = lcount;
    cmd(8'h82);
    check("R9 latch flag pulse", lcount - l0, 1);
    check("R9 busy low during latch", busy, 0);
    wclk(70);
    check("R9 busy back high", busy, 1);
    cmd(8'h80);
    wclk(70);
    l0 = lcount;
    cmd(8'h48);
    check("R9 latch md no data no latch", lcount - l0, 0);
    fall();
    send_byte(8'h48);
    send_byte(8'hF0);
    rise();
    check("R9 latch md after data", lcount - l0, 1);
    wclk(70);
    cmd(8'h40);
  endtask

  task automatic t_abort();
    cmd(8'h83);
    check("R10 disp on before abort", don, 1);
    check("R10 busy low before abort", busy, 0);
    stb = 0;
    wclk(8);
    check("R10 busy high after abort", busy, 1);
    check("R10 disp cleared", don, 0);
    send_byte(8'hC9);
    rise();
    check("R10 abort frame decoded", gaddr, 9);
    wclk(70);
    cmd(8'h80);
    wclk(70);
  endtask

  initial begin
    wclk(5);
    rst_n = 1;
    wclk(5);
    t_reset();
    t_mode();
    t_data_set();
    t_status();
    t_addr_inc();
    t_ignore();
    t_partial();
    t_addr_rst();
    t_latch();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    tests++;
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule